// File: doc/BRIEF.md
# Data-Processing Second-Operand Shifter

This combinational block builds the second operand of a data-processing instruction and the carry that the shifting stage hands on to the flag logic. It takes the 32-bit instruction word and a select that says whether the instruction uses the immediate form or the register form. It also takes two register values that have already been read: the operand register and the shift-amount register. Two further inputs are a flag saying that the operand register is the program counter, and the current carry flag.

In the immediate form, an 8-bit constant from the instruction is rotated right by twice a 4-bit field. In the register form, the operand register is shifted left, shifted right logically, shifted right arithmetically or rotated right. The amount comes either from a 5-bit instruction field or from the low byte of the shift-amount register. The encoding gives several amounts a special meaning: a zero immediate amount means 32 or rotate-through-carry, and register amounts of 32 or more have their own rules. The block applies all of these. It leaves the register-file reads, the flag writeback and the ALU to the stages around it.

Top module: `shifter_operand_gen`

## Requirements
- R1: With `imm_form` high, `operand_out` is `instr_word[7:0]`, zero-extended, rotated right by 2×`instr_word[11:8]` bit positions.
- R2: With `imm_form` high, `carry_out` equals `carry_in` when `instr_word[11:8]` is 0, and equals `operand_out[31]` otherwise.
- R3: With `imm_form` low, `instr_word[6:5]` selects the shift kind (0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right). `instr_word[4]`=0 takes the amount from `instr_word[11:7]`. `instr_word[4]`=1 takes the amount from `amt_val[7:0]`; in that case `instr_word[7]` and `amt_val[31:8]` have no effect.
- R4: A register amount of 0, and a left shift by immediate amount 0, pass the operand through unchanged with `carry_out` = `carry_in`.
- R5: For an amount n from 1 to 31, the result is the shifted or rotated operand. For a left shift `carry_out` is operand bit 32−n; for the other kinds it is operand bit n−1.
- R6: A left shift by register amount 32 gives 0 with `carry_out` equal to operand bit 0. A left shift by more than 32 gives 0 with carry 0.
- R7: A logical right shift by immediate amount 0 or by register amount 32 gives 0 with `carry_out` equal to operand bit 31. A logical right shift by register amount above 32 gives 0 with carry 0.
- R8: An arithmetic right shift by immediate amount 0, or by a register amount of 32 or more, gives 32 copies of operand bit 31, and `carry_out` equals that bit.
- R9: A rotate by immediate amount 0 gives {`carry_in`, operand[31:1]}, with `carry_out` equal to operand bit 0.
- R10: A rotate by register uses only `amt_val[4:0]` once the low byte is non-zero. When those 5 bits are 0, the result is the operand and `carry_out` is operand bit 31.
- R11: With `opnd_is_pc` high in the register form, 4 is added (modulo 2^32) to `opnd_val` before shifting. In the immediate form the flag has no effect.
- R12: `operand_out` and `carry_out` are never unknown when every input is known.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word holding the operand fields |
| imm_form | input | 1 | High selects the rotated-immediate form |
| opnd_val | input | 32 | Value read from the operand register |
| amt_val | input | 32 | Value read from the shift-amount register |
| opnd_is_pc | input | 1 | Operand register is the program counter |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Second operand for the ALU |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench goes after the amounts whose meaning depends on the encoding: 0, 1, 31, 32, 33 and 255 for each kind, in both the immediate and the register source.

A design that treated a zero immediate logical right shift as no shift would return the operand instead of zero. A design that used the whole register amount for rotates would return the operand with the carry kept, where amount 33 should rotate by one. A design that dropped carry bit 0 at a left shift of exactly 32 would report a zero carry.

Further checks catch other mistakes. One is an arithmetic saturation that zero-fills a negative operand. Another is a rotate-through-carry that moves the wrong bit into position 31. A third is a program-counter offset added after the shift rather than before it. The immediate rotator is checked at rotate fields 0, 1, 4 and 15, to expose single rather than doubled rotation and a carry taken from the wrong end.

// File: rtl/shifter_operand_pkg.sv
package shifter_operand_pkg;

    localparam int INSTR_W = 32;
    localparam int AMT_W   = 8;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e      kind;
        logic             by_reg;
        logic [AMT_W-1:0] amount;
    } shift_req_t;

    // Field positions of the register form; a register amount uses only its low byte.
    function automatic shift_req_t decode_req(input logic [INSTR_W-1:0] iw,
                                              input logic [AMT_W-1:0]   reg_amt);
        shift_req_t r;
        r.kind   = shift_kind_e'(iw[6:5]);
        r.by_reg = iw[4];
        r.amount = iw[4] ? reg_amt : {{(AMT_W-5){1'b0}}, iw[11:7]};
        return r;
    endfunction

endpackage

// File: rtl/shifter_imm_rotator.sv
module shifter_imm_rotator #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm_bits,
    input  logic [ROT_W-1:0]  rot_field,
    input  logic              carry_in,
    output logic [DATA_W-1:0] value,
    output logic              carry
);
    localparam int RA_W = ROT_W + 1;

    logic [RA_W-1:0]     rot_amt;
    logic [DATA_W-1:0]   ext;
    logic [2*DATA_W-1:0] dbl;
    logic                unused_rot_hi;

    assign rot_amt       = {rot_field, 1'b0};
    assign ext           = {{(DATA_W-IMM_W){1'b0}}, imm_bits};
    assign dbl           = {ext, ext} >> rot_amt;
    assign value         = dbl[DATA_W-1:0];
    assign unused_rot_hi = ^dbl[2*DATA_W-1:DATA_W];
    assign carry         = (rot_field == '0) ? carry_in : value[DATA_W-1];
endmodule

// File: rtl/shifter_opnd_prep.sv
module shifter_opnd_prep #(
    parameter int DATA_W    = 32,
    parameter int PC_OFFSET = 4
) (
    input  logic [DATA_W-1:0] raw_val,
    input  logic              is_pc,
    output logic [DATA_W-1:0] adj_val
);
    localparam logic [DATA_W-1:0] OFFS = DATA_W'(PC_OFFSET);

    assign adj_val = is_pc ? (raw_val + OFFS) : raw_val;
endmodule

// File: rtl/shifter_barrel.sv
module shifter_barrel
    import shifter_operand_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  shift_req_t        req,
    input  logic [DATA_W-1:0] src,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    localparam int SHW = $clog2(DATA_W);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

    logic [SHW-1:0]      sh;
    logic                amt_zero, amt_full, amt_over;
    logic [DATA_W:0]     lsl_ext, lsr_ext, asr_ext;
    logic [2*DATA_W-1:0] ror_dbl;
    logic                unused_ror_hi;
    logic                sign;

    assign sh       = req.amount[SHW-1:0];
    assign amt_zero = (req.amount == '0);
    assign amt_full = (req.amount == FULL);
    assign amt_over = (req.amount > FULL);
    assign sign     = src[DATA_W-1];

    // Each path carries one extra bit that receives the last bit shifted out.
    assign lsl_ext = {1'b0, src} << sh;
    assign lsr_ext = {src, 1'b0} >> sh;
    assign asr_ext = $unsigned($signed({src, 1'b0}) >>> sh);
    assign ror_dbl = {src, src} >> sh;
    assign unused_ror_hi = ^ror_dbl[2*DATA_W-1:DATA_W];

    always_comb begin
        result = src;
        carry  = carry_in;
        if (amt_zero) begin
            if (!req.by_reg) begin
                unique case (req.kind)
                    SK_LSL: begin result = src;                       carry = carry_in; end
                    SK_LSR: begin result = '0;                        carry = sign;     end
                    SK_ASR: begin result = {DATA_W{sign}};            carry = sign;     end
                    SK_ROR: begin result = {carry_in, src[DATA_W-1:1]}; carry = src[0]; end
                    default: ;
                endcase
            end
        end else begin
            unique case (req.kind)
                SK_LSL: begin
                    if (amt_full || amt_over) begin
                        result = '0;
                        carry  = amt_full ? src[0] : 1'b0;
                    end else begin
                        result = lsl_ext[DATA_W-1:0];
                        carry  = lsl_ext[DATA_W];
                    end
                end
                SK_LSR: begin
                    if (amt_full || amt_over) begin
                        result = '0;
                        carry  = amt_full ? sign : 1'b0;
                    end else begin
                        result = lsr_ext[DATA_W:1];
                        carry  = lsr_ext[0];
                    end
                end
                SK_ASR: begin
                    if (amt_full || amt_over) begin
                        result = {DATA_W{sign}};
                        carry  = sign;
                    end else begin
                        result = asr_ext[DATA_W:1];
                        carry  = asr_ext[0];
                    end
                end
                SK_ROR: begin
                    if (sh == '0) begin
                        result = src;
                        carry  = sign;
                    end else begin
                        result = ror_dbl[DATA_W-1:0];
                        carry  = ror_dbl[DATA_W-1];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
    import shifter_operand_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PC_OFFSET = 4
) (
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               imm_form,
    input  logic [DATA_W-1:0]  opnd_val,
    input  logic [DATA_W-1:0]  amt_val,
    input  logic               opnd_is_pc,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  operand_out,
    output logic               carry_out
);
    shift_req_t        req;
    logic [DATA_W-1:0] adj_val;
    logic [DATA_W-1:0] imm_val, reg_val;
    logic              imm_c, reg_c;
    logic              unused_inputs;

    assign req = decode_req(instr_word, amt_val[AMT_W-1:0]);
    assign unused_inputs = ^{instr_word[INSTR_W-1:12], instr_word[3:0],
                             amt_val[DATA_W-1:AMT_W]};

    shifter_imm_rotator #(.DATA_W(DATA_W), .IMM_W(8), .ROT_W(4)) u_rot (
        .imm_bits  (instr_word[7:0]),
        .rot_field (instr_word[11:8]),
        .carry_in  (carry_in),
        .value     (imm_val),
        .carry     (imm_c)
    );

    shifter_opnd_prep #(.DATA_W(DATA_W), .PC_OFFSET(PC_OFFSET)) u_prep (
        .raw_val (opnd_val),
        .is_pc   (opnd_is_pc),
        .adj_val (adj_val)
    );

    shifter_barrel #(.DATA_W(DATA_W)) u_barrel (
        .req      (req),
        .src      (adj_val),
        .carry_in (carry_in),
        .result   (reg_val),
        .carry    (reg_c)
    );

    assign operand_out = imm_form ? imm_val : reg_val;
    assign carry_out   = imm_form ? imm_c   : reg_c;
endmodule

// File: rtl/shifter_operand_chk.sv
module shifter_operand_chk #(
    parameter int DATA_W = 32
) (
    input logic [31:0]       instr_word,
    input logic              imm_form,
    input logic [DATA_W-1:0] opnd_val,
    input logic [DATA_W-1:0] amt_val,
    input logic              opnd_is_pc,
    input logic              carry_in,
    input logic [DATA_W-1:0] operand_out,
    input logic              carry_out
);
    logic [1:0] kind;
    logic       by_reg, ins_known;
    logic [7:0] ramt;
    logic       unused_chk;

    assign kind   = instr_word[6:5];
    assign by_reg = instr_word[4];
    assign ramt   = amt_val[7:0];
    assign unused_chk = ^{instr_word[31:12], instr_word[3:0], amt_val[DATA_W-1:8]};
    assign ins_known = !$isunknown({instr_word, imm_form, opnd_val, amt_val,
                                    opnd_is_pc, carry_in});

    always_comb begin
        if (ins_known) begin
            assert_no_x_R12: assert (!$isunknown({operand_out, carry_out}));
            if (imm_form && instr_word[11:8] == 4'd0)
                assert_imm_carry_keep_R2: assert (carry_out == carry_in);
            if (imm_form && instr_word[11:8] != 4'd0)
                assert_imm_carry_top_R2: assert (carry_out == operand_out[DATA_W-1]);
            if (!imm_form && by_reg && ramt == 8'd0)
                assert_reg_zero_keep_R4: assert (carry_out == carry_in);
            if (!imm_form && by_reg && kind == 2'd0 && ramt > 8'd32)
                assert_lsl_over_R6: assert (operand_out == '0 && !carry_out);
            if (!imm_form && !by_reg && kind == 2'd1 && instr_word[11:7] == 5'd0 && !opnd_is_pc)
                assert_lsr_imm0_R7: assert (operand_out == '0 && carry_out == opnd_val[DATA_W-1]);
            if (!imm_form && !by_reg && kind == 2'd2 && instr_word[11:7] == 5'd0)
                assert_asr_fill_R8: assert (operand_out == {DATA_W{carry_out}});
            if (!imm_form && !by_reg && kind == 2'd3 && instr_word[11:7] == 5'd0 && !opnd_is_pc)
                assert_rrx_R9: assert (operand_out[DATA_W-1] == carry_in && carry_out == opnd_val[0]);
        end
    end
endmodule

bind shifter_operand_gen shifter_operand_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/shifter_operand_gen_tb.sv
`timescale 1ns/1ps
module shifter_operand_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_word = '0;
    logic        imm_form = 1'b0;
    logic [31:0] opnd_val = '0;
    logic [31:0] amt_val = '0;
    logic        opnd_is_pc = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] operand_out;
    logic        carry_out;

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    shifter_operand_gen u_dut (
        .instr_word (instr_word),
        .imm_form   (imm_form),
        .opnd_val   (opnd_val),
        .amt_val    (amt_val),
        .opnd_is_pc (opnd_is_pc),
        .carry_in   (carry_in),
        .operand_out(operand_out),
        .carry_out  (carry_out)
    );

    function automatic logic [31:0] enc_imm(input logic [1:0] k, input logic [4:0] n);
        return {20'd0, n, k, 1'b0, 4'd0};
    endfunction
    function automatic logic [31:0] enc_reg(input logic [1:0] k);
        return {20'd0, 4'd1, 1'b0, k, 1'b1, 4'd2};
    endfunction
    function automatic logic [31:0] enc_rot(input logic [3:0] r, input logic [7:0] b);
        return {20'd0, r, b};
    endfunction

    // Bit-serial reference built from the requirement text.
    function automatic logic [32:0] ref_model(input logic [31:0] iw, input logic immf,
            input logic [31:0] op, input logic [31:0] ra, input logic pc, input logic c);
        logic [31:0] v;
        logic co;
        int n, k;
        co = c;
        if (immf) begin
            v = {24'd0, iw[7:0]};
            for (int i = 0; i < 2*iw[11:8]; i++) v = {v[0], v[31:1]};
            if (iw[11:8] != 0) co = v[31];
            return {co, v};
        end
        v = op + (pc ? 32'd4 : 32'd0);
        if (!iw[4]) begin
            n = int'(iw[11:7]);
            if (n == 0) begin
                case (iw[6:5])
                    2'd0: return {c, v};
                    2'd1: return {v[31], 32'd0};
                    2'd2: return {v[31], {32{v[31]}}};
                    default: return {v[0], c, v[31:1]};
                endcase
            end
        end else begin
            n = int'(ra[7:0]);
            if (n == 0) return {c, v};
        end
        case (iw[6:5])
            2'd0: for (int i = 0; i < n; i++) begin co = v[31]; v = v << 1; end
            2'd1: for (int i = 0; i < n; i++) begin co = v[0]; v = v >> 1; end
            2'd2: for (int i = 0; i < n; i++) begin co = v[0]; v = {v[31], v[31:1]}; end
            default: begin
                k = iw[4] ? int'(ra[4:0]) : n;
                if (k == 0) co = v[31];
                for (int i = 0; i < k; i++) begin co = v[0]; v = {v[0], v[31:1]}; end
            end
        endcase
        return {co, v};
    endfunction

    task automatic drive(input logic [31:0] iw, input logic immf, input logic [31:0] op,
                         input logic [31:0] ra, input logic pc, input logic c);
        @(negedge clk);
        instr_word = iw; imm_form = immf; opnd_val = op;
        amt_val = ra; opnd_is_pc = pc; carry_in = c;
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] exp_v, input logic exp_c);
        n_checks++;
        if (operand_out !== exp_v || carry_out !== exp_c) begin
            n_errs++;
            $display("FAIL %s: got %h/%b expected %h/%b (iw=%h imm=%b op=%h ra=%h pc=%b c=%b)",
                     req, operand_out, carry_out, exp_v, exp_c,
                     instr_word, imm_form, opnd_val, amt_val, opnd_is_pc, carry_in);
        end
    endtask

    task automatic check_ref(input string req);
        logic [32:0] e;
        e = ref_model(instr_word, imm_form, opnd_val, amt_val, opnd_is_pc, carry_in);
        check(req, e[31:0], e[32]);
    endtask

    task automatic t_reset;
        drive(32'd0, 1'b0, 32'd0, 32'd0, 1'b0, 1'b0);
        check("R4 reset idle", 32'd0, 1'b0);
    endtask

    task automatic t_immediate;
        drive(enc_rot(4'd0, 8'hAB), 1'b1, 32'h0, 32'h0, 1'b0, 1'b1);
        check("R1 R2 rot0", 32'h0000_00AB, 1'b1);
        drive(enc_rot(4'd4, 8'hFF), 1'b1, 32'h0, 32'h0, 1'b0, 1'b0);
        check("R1 R2 rot4", 32'hFF00_0000, 1'b1);
        drive(enc_rot(4'd1, 8'h01), 1'b1, 32'h0, 32'h0, 1'b0, 1'b1);
        check("R1 R2 rot1", 32'h4000_0000, 1'b0);
        drive(enc_rot(4'd15, 8'h80), 1'b1, 32'h0, 32'h0, 1'b0, 1'b1);
        check("R1 R2 rot15", 32'h0000_0200, 1'b0);
        drive(enc_rot(4'd15, 8'h80), 1'b1, 32'h1234, 32'h0, 1'b1, 1'b1);
        check("R11 pc ignored in immediate", 32'h0000_0200, 1'b0);
    endtask

    task automatic t_imm_zero;
        drive(enc_imm(2'd0, 5'd0), 1'b0, 32'h8000_0001, 32'h0, 1'b0, 1'b1);
        check("R4 lsl imm0", 32'h8000_0001, 1'b1);
        drive(enc_imm(2'd1, 5'd0), 1'b0, 32'h8000_0001, 32'h0, 1'b0, 1'b0);
        check("R7 lsr imm0", 32'h0, 1'b1);
        drive(enc_imm(2'd2, 5'd0), 1'b0, 32'h8000_0001, 32'h0, 1'b0, 1'b0);
        check("R8 asr imm0", 32'hFFFF_FFFF, 1'b1);
        drive(enc_imm(2'd2, 5'd0), 1'b0, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b1);
        check("R8 asr imm0 positive", 32'h0, 1'b0);
        drive(enc_imm(2'd3, 5'd0), 1'b0, 32'h8000_0001, 32'h0, 1'b0, 1'b1);
        check("R9 rrx", 32'hC000_0000, 1'b1);
        drive(enc_imm(2'd3, 5'd0), 1'b0, 32'h0000_0002, 32'h0, 1'b0, 1'b0);
        check("R9 rrx carry0", 32'h0000_0001, 1'b0);
    endtask

    task automatic t_imm_ordinary;
        drive(enc_imm(2'd0, 5'd1), 1'b0, 32'h8000_0003, 32'h0, 1'b0, 1'b0);
        check("R5 lsl1", 32'h0000_0006, 1'b1);
        drive(enc_imm(2'd1, 5'd31), 1'b0, 32'hC000_0000, 32'h0, 1'b0, 1'b0);
        check("R5 lsr31", 32'h0000_0001, 1'b1);
        drive(enc_imm(2'd2, 5'd4), 1'b0, 32'h8000_0018, 32'h0, 1'b0, 1'b0);
        check("R5 asr4", 32'hF800_0001, 1'b1);
        drive(enc_imm(2'd3, 5'd8), 1'b0, 32'h1234_5680, 32'h0, 1'b0, 1'b0);
        check("R5 ror8", 32'h8012_3456, 1'b1);
        for (int k = 0; k < 4; k++) begin
            drive(enc_imm(2'(k), 5'd31), 1'b0, 32'hA5A5_0F0F, 32'h0, 1'b0, 1'b1);
            check_ref("R5 imm amount 31");
        end
    endtask

    task automatic t_reg_amounts;
        int amts[6] = '{0, 1, 31, 32, 33, 255};
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 6; a++) begin
                drive(enc_reg(2'(k)), 1'b0, 32'h8000_0003, 32'(amts[a]), 1'b0, 1'b1);
                check_ref("R5 R6 R7 R8 R10 register amount sweep");
            end
        drive(enc_reg(2'd0), 1'b0, 32'h8000_0003, 32'd0, 1'b0, 1'b1);
        check("R4 reg amount 0", 32'h8000_0003, 1'b1);
        drive(enc_reg(2'd0), 1'b0, 32'h8000_0003, 32'd32, 1'b0, 1'b0);
        check("R6 lsl reg32", 32'h0, 1'b1);
        drive(enc_reg(2'd0), 1'b0, 32'hFFFF_FFFF, 32'd33, 1'b0, 1'b1);
        check("R6 lsl reg33", 32'h0, 1'b0);
        drive(enc_reg(2'd1), 1'b0, 32'h8000_0000, 32'd32, 1'b0, 1'b0);
        check("R7 lsr reg32", 32'h0, 1'b1);
        drive(enc_reg(2'd1), 1'b0, 32'hFFFF_FFFF, 32'd33, 1'b0, 1'b1);
        check("R7 lsr reg33", 32'h0, 1'b0);
        drive(enc_reg(2'd2), 1'b0, 32'h8000_0000, 32'd255, 1'b0, 1'b0);
        check("R8 asr reg255", 32'hFFFF_FFFF, 1'b1);
        drive(enc_reg(2'd3), 1'b0, 32'h0000_0001, 32'd32, 1'b0, 1'b1);
        check("R10 ror reg32", 32'h0000_0001, 1'b0);
        drive(enc_reg(2'd3), 1'b0, 32'h8000_0000, 32'd64, 1'b0, 1'b0);
        check("R10 ror reg64", 32'h8000_0000, 1'b1);
        drive(enc_reg(2'd3), 1'b0, 32'h0000_0001, 32'd33, 1'b0, 1'b0);
        check("R10 ror reg33", 32'h8000_0000, 1'b1);
    endtask

    task automatic t_field_decode;
        drive(enc_reg(2'd1) | 32'h80, 1'b0, 32'h0000_00F0, 32'd4, 1'b0, 1'b0);
        check("R3 bit7 ignored with register amount", 32'h0000_000F, 1'b0);
        drive(enc_reg(2'd0), 1'b0, 32'h1234_5678, 32'hFFFF_FF00, 1'b0, 1'b1);
        check("R3 upper amount bits ignored", 32'h1234_5678, 1'b1);
        drive(enc_reg(2'd0), 1'b0, 32'h0000_0001, 32'hABCD_0004, 1'b0, 1'b0);
        check("R3 low byte amount", 32'h0000_0010, 1'b0);
    endtask

    task automatic t_pc;
        drive(enc_imm(2'd0, 5'd2), 1'b0, 32'h0000_0010, 32'h0, 1'b1, 1'b0);
        check("R11 pc offset before lsl", 32'h0000_0050, 1'b0);
        drive(enc_reg(2'd1), 1'b0, 32'hFFFF_FFFE, 32'd1, 1'b1, 1'b1);
        check("R11 pc offset wraps", 32'h0000_0001, 1'b0);
    endtask

    task automatic t_random;
        logic [31:0] s;
        logic [31:0] iw, op, ra;
        s = 32'h1ACE_B00C;
        for (int i = 0; i < 1500; i++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            iw = s;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            op = s;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            ra = s;
            if (ra[9:8] == 2'b00) ra[7:0] = {2'b00, ra[5:0]};
            drive(iw, s[10], op, ra, s[11] & s[12], s[13]);
            n_checks++;
            if ($isunknown({operand_out, carry_out})) begin
                n_errs++;
                $display("FAIL R12: got %h/%b expected no unknown bits", operand_out, carry_out);
            end
            check_ref("R5 random against model");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_immediate();
        t_imm_zero();
        t_imm_ordinary();
        t_reg_amounts();
        t_field_decode();
        t_pc();
        t_random();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule